// File: doc/BRIEF.md
# Router Packet Byte Register with Parity Check

This block is the byte-wide staging register between a router's single input port and its per-destination output queues. A separate packet controller drives it with one-hot phase strobes. In the address phase the block keeps the header byte in a holding register, so the controller can first wait until the chosen queue has room. It then puts the header, the payload bytes and the packet's parity byte, one by one, on a single output bus that feeds the queue write port.

If a payload byte arrives in the same cycle that the target queue reports full, the byte cannot be written at once. The block stores it in a one-byte spill register and drives it out again when the controller signals the replay phase after the stall.

The block keeps a running XOR of the packet's bytes and also stores the parity byte carried in the packet. When the controller signals the check phase, the block compares the two, updates its error flag and clears its per-packet state. Two status flags go back to the controller and steer its recovery path after a stall: one reports that the input valid has dropped, the other reports that the parity byte has been taken.

Top module: `rdr_top`

## Requirements
- R1: While rstN is low at a rising clock edge, dout, err, parityDone and lowPktValid all become 0 at that edge.
- R2: When addrPhase and pktValid are both high at an edge, dataIn is stored as the header. When hdrLoad is high at a later edge, dout takes the stored header.
- R3: When dataLoad is high and fifoFull is low at an edge, dout takes dataIn.
- R4: When dataLoad and fifoFull are both high at an edge, dout keeps its value and dataIn goes into the spill register. When replayLoad is high at a later edge, dout takes the spilled byte.
- R5: When parityLoad is high and fifoFull is low at an edge, dout takes dataIn and that byte is stored as the packet parity. When parityLoad is high and fifoFull is high, dout and the stored parity are left unchanged.
- R6: The running parity restarts at the header byte. It is then XORed with every byte that is present at an edge where dataLoad and pktValid are both high, whether fifoFull is high or low.
- R7: When checkClear is high at an edge, err takes (running parity != stored packet parity), and both parity registers are cleared. err changes at no other edge except under reset.
- R8: lowPktValid is set at an edge where dataLoad is high and pktValid is low, and it is cleared at an edge where checkClear is high.
- R9: parityDone is set at an edge where dataLoad is high and both fifoFull and pktValid are low. It is also set at an edge where replayLoad and lowPktValid are high while parityDone is low. It is cleared at an edge where checkClear is high, and clearing takes priority over setting.
- R10: dout holds its value at any edge where none of these cases applies: hdrLoad, dataLoad with fifoFull low, parityLoad with fifoFull low, or replayLoad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| addrPhase | input | 1 | Controller strobe: address phase, header byte on dataIn |
| hdrLoad | input | 1 | Controller strobe: drive the stored header |
| dataLoad | input | 1 | Controller strobe: payload phase |
| parityLoad | input | 1 | Controller strobe: parity byte phase |
| replayLoad | input | 1 | Controller strobe: replay the spilled byte |
| checkClear | input | 1 | Controller strobe: compare parity and clear per-packet state |
| pktValid | input | 1 | Input packet valid |
| fifoFull | input | 1 | Full flag of the selected output queue |
| dataIn | input | DATA_W | Input byte |
| dout | output | DATA_W | Byte presented to the output queue write port |
| err | output | 1 | Parity mismatch found at the most recent check |
| parityDone | output | 1 | Parity byte has been taken |
| lowPktValid | output | 1 | pktValid was seen low during the payload phase |

## Verification
The hardest situation to reach is a stall that lands on the parity byte itself. Here valid drops in the same cycle that the queue fills. lowPktValid is then set, but parityDone is not, and parityDone is only set later by the replay phase. The stimulus forces this path on purpose in a fraction of the packets. The remaining packets get random payload lengths, random full pulses on payload bytes, and a random choice of correct or corrupted parity.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef struct packed {
    logic capHdr;
    logic emitHdr;
    logic emitPay;
    logic keepSpill;
    logic emitPar;
    logic emitSpill;
    logic foldIn;
    logic check;
  } dpCtl_t;
endpackage

// File: rtl/rdr_ctl.sv
module rdr_ctl
  import rdr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   addrPhase,
  input  logic   hdrLoad,
  input  logic   dataLoad,
  input  logic   parityLoad,
  input  logic   replayLoad,
  input  logic   checkClear,
  input  logic   pktValid,
  input  logic   fifoFull,
  output dpCtl_t ctl,
  output logic   parityDone,
  output logic   lowPktValid
);
  always_comb begin
    ctl.capHdr    = addrPhase & pktValid;
    ctl.emitHdr   = hdrLoad;
    ctl.emitPay   = dataLoad & ~fifoFull;
    ctl.keepSpill = dataLoad & fifoFull;
    ctl.emitPar   = parityLoad & ~fifoFull;
    ctl.emitSpill = replayLoad;
    ctl.foldIn    = dataLoad & pktValid;
    ctl.check     = checkClear;
  end

  // Status flags returned to the packet controller
  always_ff @(posedge clk) begin
    if (!rstN) begin
      parityDone  <= 1'b0;
      lowPktValid <= 1'b0;
    end else if (checkClear) begin
      parityDone  <= 1'b0;
      lowPktValid <= 1'b0;
    end else begin
      if ((dataLoad && !fifoFull && !pktValid) ||
          (replayLoad && lowPktValid && !parityDone))
        parityDone <= 1'b1;
      if (dataLoad && !pktValid)
        lowPktValid <= 1'b1;
    end
  end
endmodule

// File: rtl/rdr_dp.sv
module rdr_dp
  import rdr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dout,
  output logic              err
);
  logic [DATA_W-1:0] hdrByte;
  logic [DATA_W-1:0] spillByte;
  logic [DATA_W-1:0] runPar;
  logic [DATA_W-1:0] pktPar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrByte   <= '0;
      spillByte <= '0;
      dout      <= '0;
    end else begin
      if (ctl.capHdr)    hdrByte   <= dataIn;
      if (ctl.keepSpill) spillByte <= dataIn;
      if (ctl.emitHdr)        dout <= hdrByte;
      else if (ctl.emitPay)   dout <= dataIn;
      else if (ctl.emitPar)   dout <= dataIn;
      else if (ctl.emitSpill) dout <= spillByte;
    end
  end

  // Running parity, stored packet parity and the error flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runPar <= '0;
      pktPar <= '0;
      err    <= 1'b0;
    end else if (ctl.check) begin
      err    <= (runPar != pktPar);
      runPar <= '0;
      pktPar <= '0;
    end else begin
      if (ctl.capHdr)      runPar <= dataIn;
      else if (ctl.foldIn) runPar <= runPar ^ dataIn;
      if (ctl.emitPar)     pktPar <= dataIn;
    end
  end
endmodule

// File: rtl/rdr_top.sv
module rdr_top
  import rdr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrPhase,
  input  logic              hdrLoad,
  input  logic              dataLoad,
  input  logic              parityLoad,
  input  logic              replayLoad,
  input  logic              checkClear,
  input  logic              pktValid,
  input  logic              fifoFull,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dout,
  output logic              err,
  output logic              parityDone,
  output logic              lowPktValid
);
  dpCtl_t ctl;

  rdr_ctl u_ctl (
    .clk(clk), .rstN(rstN), .addrPhase(addrPhase), .hdrLoad(hdrLoad),
    .dataLoad(dataLoad), .parityLoad(parityLoad), .replayLoad(replayLoad),
    .checkClear(checkClear), .pktValid(pktValid), .fifoFull(fifoFull),
    .ctl(ctl), .parityDone(parityDone), .lowPktValid(lowPktValid)
  );

  rdr_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(dataIn),
    .dout(dout), .err(err)
  );
endmodule

// File: rtl/rdr_chk.sv
module rdr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrPhase,
  input logic              hdrLoad,
  input logic              dataLoad,
  input logic              parityLoad,
  input logic              replayLoad,
  input logic              checkClear,
  input logic              pktValid,
  input logic              fifoFull,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] dout,
  input logic              err,
  input logic              parityDone,
  input logic              lowPktValid
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (dout == '0 && !err && !parityDone && !lowPktValid));

  a_r3_pass_payload: assert property (@(posedge clk) disable iff (!rstN)
    (dataLoad && !fifoFull && !hdrLoad) |=> dout == $past(dataIn));

  a_r7_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    !checkClear |=> $stable(err));

  a_r8_low_set: assert property (@(posedge clk) disable iff (!rstN)
    (dataLoad && !pktValid && !checkClear) |=> lowPktValid);

  a_r9_clear_flags: assert property (@(posedge clk) disable iff (!rstN)
    checkClear |=> (!parityDone && !lowPktValid));

  a_r10_dout_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(hdrLoad || (dataLoad && !fifoFull) || (parityLoad && !fifoFull) || replayLoad)
    |=> $stable(dout));
endmodule

bind rdr_top rdr_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_rdr_top.sv
module sim_rdr_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrPhase = 0, hdrLoad = 0, dataLoad = 0, parityLoad = 0, replayLoad = 0, checkClear = 0;
  logic pktValid = 0, fifoFull = 0;
  logic [7:0] dataIn = '0;
  logic [7:0] dout;
  logic err, parityDone, lowPktValid;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  // Bench reference state, derived from the requirements
  logic [7:0] mHdr = 0, mSpill = 0, mRun = 0, mPar = 0, mDout = 0;
  logic mErr = 0, mPd = 0, mLow = 0;

  localparam logic [5:0] S_ADDR = 6'b000001, S_HDR = 6'b000010, S_DATA = 6'b000100,
                         S_PAR = 6'b001000, S_REP = 6'b010000, S_CHK = 6'b100000,
                         S_NONE = 6'b000000;

  always #10 clk = ~clk;

  rdr_top u0 (.*);

  function automatic logic [7:0] xorFold(input logic [7:0] acc, input logic [7:0] b);
    return acc ^ b;
  endfunction

  task automatic modelStep(input logic [5:0] s, input logic pv, input logic ff, input logic [7:0] d);
    logic [7:0] nHdr, nSpill, nRun, nPar, nDout;
    logic nErr, nPd, nLow;
    nHdr = mHdr; nSpill = mSpill; nRun = mRun; nPar = mPar; nDout = mDout;
    nErr = mErr; nPd = mPd; nLow = mLow;
    if (!rstN) begin
      nDout = 0; nErr = 0; nPd = 0; nLow = 0; nRun = 0; nPar = 0; nHdr = 0; nSpill = 0;
    end else begin
      if (s[0] && pv) begin nHdr = d; nRun = d; end
      if (s[2] && pv) nRun = xorFold(mRun, d);
      if (s[2] && ff) nSpill = d;
      if (s[3] && !ff) nPar = d;
      if (s[1]) nDout = mHdr;
      else if (s[2] && !ff) nDout = d;
      else if (s[3] && !ff) nDout = d;
      else if (s[4]) nDout = mSpill;
      if (s[5]) begin
        nErr = (mRun != mPar); nRun = 0; nPar = 0; nPd = 0; nLow = 0;
      end else begin
        if ((s[2] && !ff && !pv) || (s[4] && mLow && !mPd)) nPd = 1;
        if (s[2] && !pv) nLow = 1;
      end
    end
    mHdr = nHdr; mSpill = nSpill; mRun = nRun; mPar = nPar; mDout = nDout;
    mErr = nErr; mPd = nPd; mLow = nLow;
  endtask

  task automatic step(input logic [5:0] s, input logic pv, input logic ff,
                      input logic [7:0] d, input string tag);
    @(negedge clk);
    {checkClear, replayLoad, parityLoad, dataLoad, hdrLoad, addrPhase} = s;
    pktValid = pv; fifoFull = ff; dataIn = d;
    modelStep(s, pv, ff, d);
    @(posedge clk);
    #5;
    nRun++;
    if (dout !== mDout || err !== mErr || parityDone !== mPd || lowPktValid !== mLow) begin
      nFail++;
      $display("FAIL %s: dout=%h err=%b pd=%b low=%b expected dout=%h err=%b pd=%b low=%b",
               tag, dout, err, parityDone, lowPktValid, mDout, mErr, mPd, mLow);
    end
  endtask

  task automatic packet(input int len, input bit corrupt, input bit lastStall);
    logic [7:0] b, par;
    b = 8'($urandom);
    par = b;
    step(S_ADDR, 1, 0, b, "R2");
    step(S_HDR, 0, 0, 8'($urandom), "R2");
    for (int i = 0; i < len; i++) begin
      logic ff;
      b = 8'($urandom);
      ff = ($urandom % 4 == 0);
      par = par ^ b;
      step(S_DATA, 1, ff, b, ff ? "R4" : "R3 R6");
      if (ff) begin
        step(S_NONE, 1, 1, 8'($urandom), "R10");
        step(S_REP, 1, 0, 8'($urandom), "R4");
      end
    end
    if (corrupt) par = par ^ 8'h5a;
    if (lastStall) begin
      step(S_DATA, 0, 1, par, "R8");
      step(S_REP, 0, 0, 8'($urandom), "R9");
    end else begin
      step(S_DATA, 0, 0, par, "R9 R8");
    end
    step(S_PAR, 0, 0, par, "R5");
    step(S_CHK, 0, 0, 8'($urandom), "R7 R6");
  endtask

  initial begin
    void'($urandom(32'hC0FFEE));
    rstN = 0;
    step(S_NONE, 0, 0, 8'h00, "R1");
    step(S_NONE, 0, 0, 8'h00, "R1");
    rstN = 1;
    // Directed: clean packet, corrupt packet, stall on parity byte
    packet(3, 0, 0);
    packet(2, 1, 0);
    packet(1, 0, 1);
    packet(4, 1, 1);
    // Directed: parity phase while full is ignored, then idle hold
    step(S_PAR, 0, 1, 8'hA5, "R5");
    step(S_NONE, 1, 0, 8'h3C, "R10");
    step(S_CHK, 0, 0, 8'h00, "R7");
    // Random packets
    for (int p = 0; p < 60; p++)
      packet(1 + int'($urandom % 8), ($urandom % 3) == 0, ($urandom % 5) == 0);
    // Reset in the middle of a packet
    step(S_ADDR, 1, 0, 8'h77, "R2");
    step(S_DATA, 1, 0, 8'h12, "R3");
    rstN = 0;
    step(S_DATA, 0, 0, 8'h34, "R1");
    rstN = 1;
    step(S_NONE, 0, 0, 8'h00, "R1");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule